// File: doc/BRIEF.md
# Frame-Synced Serial Audio Word Transmitter

This block sends one audio word per frame on a single serial data line. A frame begins on a rising edge of an incoming frame sync signal. After that edge, the block puts one bit of the current word on the data line for each rising edge of an incoming shift clock, starting with the most significant bit. Both timing signals come from outside. The block samples them in its own system clock domain and finds their rising edges by comparing each sample with the one before it.

Words reach the block through a single holding register that a DMA-style write port fills. The request output is high whenever that register is empty. When the last bit of a word has gone out, the word register takes the held value and the request rises again. If nothing was written in time, the word register keeps its contents and the same word goes out again in the next frame. A select input picks 16-bit or 8-bit words. In 8-bit mode only the low byte is sent.

Top module: `frame_audio_tx`

## Requirements
- R1: After reset the request output is 1, the data output is 0 and the word register is zero, so a frame started before any reload sends all zeros.
- R2: While enabled, a rising edge of the sampled frame sync starts a frame. Each later rising edge of the sampled shift clock puts the next bit on the data output, most significant bit first, within SYNC_STAGES+2 system clocks of the shift clock edge.
- R3: The word-length select is sampled at the frame sync. Value 1 sends 16 bits, bit 15 first. Value 0 sends bits 7 down to 0, and the upper byte of the word never reaches the output.
- R4: After the last bit of a frame, each further shift clock rising edge drives the data output to 0 until the next frame sync.
- R5: On the shift clock edge that sends the last bit, the word register is loaded from the holding register if that register is full. The next frame sends the new word.
- R6: If the holding register is empty when the last bit goes out, the word register keeps its contents and the previous word is sent again in the next frame.
- R7: The request output equals "holding register empty". A write clears it on the next clock, and a reload with no write in the same cycle sets it again.
- R8: A write to a full holding register replaces the held word. The earlier held word is never sent.
- R9: While disabled, the data output is 0, frame syncs and shift clocks have no effect and the word register keeps its contents. Disabling in the middle of a frame ends that frame without a reload.
- R10: A frame sync that arrives in the middle of a frame restarts the same word from its most significant bit, without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable |
| wideMode | input | 1 | Word length: 1 for 16-bit, 0 for 8-bit (low byte) |
| frameSyncIn | input | 1 | External frame sync, asynchronous to clk |
| shiftClkIn | input | 1 | External shift clock, asynchronous to clk |
| holdWrEn | input | 1 | Write strobe for the holding register |
| holdWrData | input | WORD_W | Word written into the holding register |
| dmaReq | output | 1 | High while the holding register is empty |
| txData | output | 1 | Serial data output |

## Verification
The bench builds the block with WORD_W=16 and SYNC_STAGES=2. With these values both word lengths can be tested, and a walking-one pattern mixed with an arithmetic pattern reaches every bit position of the word in each mode. Every output bit is compared with a model of the word register and the holding register. The sweep skips some writes to force re-sends, writes twice in a row to test overwrites, and also covers a mid-frame resync, a mid-frame disable and idle shift clocks after each frame.

// File: rtl/fatx_pkg.sv
package fatx_pkg;

  // Strobes passed from the control module to the datapath each system clock.
  typedef struct packed {
    logic shiftBit;   // put the selected word bit on the data output
    logic idleBit;    // shift clock edge outside a frame: drive 0
    logic reload;     // last bit sent: take the holding register if full
    logic clearOut;   // block disabled: force the output low
  } fatxStrobe_t;

endpackage

// File: rtl/fatx_edge.sv
module fatx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic [STAGES-1:0] syncD;
  logic              prevQ;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign syncD[g] = rawIn;
    end else begin : g_next
      assign syncD[g] = syncQ[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= syncD;
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign rise = syncQ[STAGES-1] & ~prevQ;
endmodule

// File: rtl/fatx_ctrl.sv
module fatx_ctrl
  import fatx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wideMode,
  input  logic             fsRise,
  input  logic             scRise,
  output fatxStrobe_t      strobes,
  output logic [IDX_W-1:0] bitSel
);
  localparam int SHORT_W = WORD_W / 2;
  localparam logic [IDX_W-1:0] LONG_TOP  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] SHORT_TOP = IDX_W'(SHORT_W - 1);

  logic             inFrame;
  logic [IDX_W-1:0] bitCnt;
  logic             scUse;

  // A frame sync takes priority over a shift clock edge in the same cycle.
  assign scUse = enable & ~fsRise & scRise;

  always_comb begin
    strobes.shiftBit = scUse & inFrame;
    strobes.idleBit  = scUse & ~inFrame;
    strobes.reload   = scUse & inFrame & (bitCnt == '0);
    strobes.clearOut = ~enable;
  end

  assign bitSel = bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
    end else if (!enable) begin
      inFrame <= 1'b0;
    end else if (fsRise) begin
      inFrame <= 1'b1;
      bitCnt  <= wideMode ? LONG_TOP : SHORT_TOP;
    end else if (scRise && inFrame) begin
      if (bitCnt == '0) begin
        inFrame <= 1'b0;
      end else begin
        bitCnt <= bitCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fatx_datapath.sv
module fatx_datapath
  import fatx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fatxStrobe_t       strobes,
  input  logic [IDX_W-1:0]  bitSel,
  input  logic              holdWrEn,
  input  logic [WORD_W-1:0] holdWrData,
  output logic              dmaReq,
  output logic              txData
);
  logic [WORD_W-1:0] holdQ;
  logic [WORD_W-1:0] wordQ;
  logic              holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ    <= '0;
      holdFull <= 1'b0;
    end else begin
      if (holdWrEn) begin
        holdQ    <= holdWrData;
        holdFull <= 1'b1;
      end else if (strobes.reload) begin
        holdFull <= 1'b0;
      end
    end
  end

  // Without a full holding register the word stays put and is sent again.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobes.reload && holdFull) begin
      wordQ <= holdQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= 1'b0;
    end else if (strobes.clearOut || strobes.idleBit) begin
      txData <= 1'b0;
    end else if (strobes.shiftBit) begin
      txData <= wordQ[bitSel];
    end
  end

  assign dmaReq = ~holdFull;
endmodule

// File: rtl/frame_audio_tx.sv
module frame_audio_tx
  import fatx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wideMode,
  input  logic              frameSyncIn,
  input  logic              shiftClkIn,
  input  logic              holdWrEn,
  input  logic [WORD_W-1:0] holdWrData,
  output logic              dmaReq,
  output logic              txData
);
  localparam int IDX_W = $clog2(WORD_W);

  logic             fsRise;
  logic             scRise;
  fatxStrobe_t      strobes;
  logic [IDX_W-1:0] bitSel;
  logic             reloadStb;

  fatx_edge #(.STAGES(SYNC_STAGES)) fsEdge_i (
    .clk(clk), .rstN(rstN), .rawIn(frameSyncIn), .rise(fsRise)
  );

  fatx_edge #(.STAGES(SYNC_STAGES)) scEdge_i (
    .clk(clk), .rstN(rstN), .rawIn(shiftClkIn), .rise(scRise)
  );

  fatx_ctrl #(.WORD_W(WORD_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wideMode(wideMode),
    .fsRise(fsRise), .scRise(scRise), .strobes(strobes), .bitSel(bitSel)
  );

  fatx_datapath #(.WORD_W(WORD_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitSel(bitSel),
    .holdWrEn(holdWrEn), .holdWrData(holdWrData),
    .dmaReq(dmaReq), .txData(txData)
  );

  assign reloadStb = strobes.reload;
endmodule

// File: rtl/fatx_checker.sv
module fatx_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic holdWrEn,
  input logic dmaReq,
  input logic txData,
  input logic reloadStb
);
  // R7: a write empties the request on the next clock
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdWrEn |=> !dmaReq);

  // R7: a reload without a write sets the request
  p_req_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reloadStb && !holdWrEn) |=> dmaReq);

  // R7: no write and no reload leaves the request alone
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!reloadStb && !holdWrEn) |=> $stable(dmaReq));

  // R9: output low one clock after the enable is seen low
  p_tx_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txData);

  // R9: no reload while disabled
  p_no_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !reloadStb);
endmodule

bind frame_audio_tx fatx_checker chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .holdWrEn(holdWrEn),
  .dmaReq(dmaReq), .txData(txData), .reloadStb(reloadStb)
);

// File: tb/frame_audio_tx_tb_top.sv
`timescale 1ns/1ps
module frame_audio_tx_tb_top;
  localparam int WORD_W = 16;
  localparam int WAIT_N = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic wideMode = 1'b1;
  logic frameSyncIn = 1'b0;
  logic shiftClkIn = 1'b0;
  logic holdWrEn = 1'b0;
  logic [WORD_W-1:0] holdWrData = '0;
  logic dmaReq;
  logic txData;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 0;

  // model state
  logic [WORD_W-1:0] mWord = '0;
  logic [WORD_W-1:0] mHold = '0;
  bit mFull = 0;

  always #4 clk = ~clk;

  frame_audio_tx #(.WORD_W(WORD_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wideMode(wideMode),
    .frameSyncIn(frameSyncIn), .shiftClkIn(shiftClkIn),
    .holdWrEn(holdWrEn), .holdWrData(holdWrData),
    .dmaReq(dmaReq), .txData(txData)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseSync();
    frameSyncIn = 1'b1; tick(WAIT_N);
    frameSyncIn = 1'b0; tick(WAIT_N);
  endtask

  task automatic clockBit(output logic b);
    shiftClkIn = 1'b1; tick(WAIT_N);
    b = txData;
    shiftClkIn = 1'b0; tick(WAIT_N);
  endtask

  task automatic writeHold(input logic [WORD_W-1:0] d);
    chk("R7 req before write", 16'(dmaReq), 16'(!mFull));
    holdWrEn = 1'b1; holdWrData = d;
    tick(1);
    holdWrEn = 1'b0;
    chk("R7 req cleared next clock", 16'(dmaReq), 16'h0);
    mHold = d; mFull = 1;
  endtask

  // full frame: every bit checked, model reload, one idle clock checked
  task automatic runFrame(input bit wide);
    int n;
    logic b;
    n = wide ? 16 : 8;
    wideMode = wide;
    pulseSync();
    for (int i = 0; i < n; i++) begin
      clockBit(b);
      chk(wide ? "R2 R3 wide bit" : "R2 R3 byte bit", 16'(b), 16'(mWord[n-1-i]));
    end
    if (mFull) begin
      mWord = mHold; mFull = 0;
    end
    chk("R5 R6 R7 req after frame", 16'(dmaReq), 16'(!mFull));
    clockBit(b);
    chk("R4 idle shift clock", 16'(b), 16'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    logic b;
    tick(3);
    chk("R1 reset req", 16'(dmaReq), 16'h1);
    chk("R1 reset data", 16'(txData), 16'h0);
    rstN = 1'b1;
    tick(2);
    enable = 1'b1;
    tick(2);

    // R1: first frame sends the cleared word; R6 no write -> nothing reloaded
    runFrame(1);
    writeHold(16'hA5C3);
    runFrame(1); // still the zero word, reload A5C3 at end
    runFrame(1); // A5C3

    // R2 R3 R5 R6: sweep bit positions in both word lengths
    for (int k = 0; k < 16; k++) begin
      for (int w = 0; w < 2; w++) begin
        if (((k + w) % 3) != 2)
          writeHold((16'h1 << k) ^ 16'(k * 16'h0F1D + w * 16'h8421));
        runFrame(w[0]);
      end
    end

    // R8: double write, the second one wins
    writeHold(16'h1234);
    writeHold(16'hBEEF);
    runFrame(1);
    runFrame(1);
    chk("R8 overwritten word sent", mWord, 16'hBEEF);

    // R10: sync in mid frame restarts the same word, no reload
    writeHold(16'h6B2D);
    wideMode = 1'b1;
    pulseSync();
    for (int i = 0; i < 5; i++) begin
      clockBit(b);
      chk("R10 partial frame bit", 16'(b), 16'(mWord[15-i]));
    end
    chk("R10 no reload on partial frame", 16'(dmaReq), 16'h0);
    runFrame(1);

    // R9: disabled, syncs and clocks ignored, output low
    writeHold(16'hC00C);
    enable = 1'b0;
    tick(2);
    pulseSync();
    for (int i = 0; i < 18; i++) begin
      clockBit(b);
      chk("R9 data low while disabled", 16'(b), 16'h0);
    end
    chk("R9 req unchanged while disabled", 16'(dmaReq), 16'h0);
    enable = 1'b1;
    tick(2);
    runFrame(1); // word kept; reload C00C at end

    // R9: disable in mid frame, no reload
    writeHold(16'h5AF0);
    wideMode = 1'b0;
    pulseSync();
    for (int i = 0; i < 3; i++) begin
      clockBit(b);
      chk("R9 bit before abort", 16'(b), 16'(mWord[7-i]));
    end
    enable = 1'b0;
    tick(3);
    chk("R9 data low after abort", 16'(txData), 16'h0);
    chk("R9 no reload after abort", 16'(dmaReq), 16'h0);
    enable = 1'b1;
    tick(2);
    clockBit(b);
    chk("R9 R4 no frame after re-enable", 16'(b), 16'h0);
    runFrame(0);
    runFrame(1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule